// File: doc/BRIEF.md
# Prescaled Down-Counting Timer Channel

This block is one timer channel built around a 16-bit down-counter. The counter steps once per channel tick. The tick comes from a clock divider whose structure depends on the selected source. From the fast system clock, the tick passes through two cascaded dividers: a system divide stage, then a prescale stage. From the slow low-frequency input, only the prescale stage is used. The slow input is synchronized into the main clock domain and reduced to one pulse per rising edge. A divide value of N divides by N+1, so zero passes the input straight through.

Software loads a start value while the channel is stopped. It picks the source, both divide ratios and auto-reload, then requests enable or disable with single-cycle strobes. Each request takes effect after a fixed delay, and separate acknowledge flags confirm it. A zero-reached flag is set when the count steps from one to zero. In one-shot mode the counter then rests at zero. With auto-reload it restarts from the load value. Stopping the channel holds the count, and starting it again resumes from the held value. All flags are sticky until cleared, and their OR drives a registered interrupt line.

Top module: `dtimer_chan`

## Requirements
- R1: A synchronous reset clears `count`, `enabled`, all three flags and `irq` to zero.
- R2: An `en_req` pulse sampled at clock edge k makes `enabled` and `en_ack` read 1 after edge k+1. This happens two edges after the request was applied.
- R3: With `cfg_slow`=0, `cfg_sysdiv`=S and `cfg_pre`=P, the running counter decrements exactly once every (S+1)*(P+1) clock cycles.
- R4: With `cfg_slow`=1, the counter decrements once every (P+1) rising edges of `lf_clk`, and `cfg_sysdiv` has no effect.
- R5: Without auto-reload, stepping from 1 reaches 0 and sets `zero_flag`. The count then stays 0, and the flag stays set until cleared.
- R6: With `cfg_autorel`=1, stepping from 1 loads the load value instead of 0 and sets `zero_flag`. The interval between reloads is N*(S+1)*(P+1) cycles for load value N on the fast source.
- R7: A load value of zero starts no counting: after enabling, `count` stays 0 and `zero_flag` is never set.
- R8: While `enabled` is 0, `count` changes only through a load write. Re-enabling without a write resumes decrementing from the held value.
- R9: A load write (`load_we`) while `enabled` is 1 changes neither the count nor the stored load value.
- R10: A `dis_req` pulse sampled at edge k makes `enabled` read 0 and `dis_ack` read 1 after edge k+1. If both requests arrive together, disable wins.
- R11: Writing 1 to bit 0, 1 or 2 of `flag_clr` clears `zero_flag`, `en_ack` or `dis_ack` respectively. If a flag is set and cleared in the same cycle, the set wins. `irq` reads 1 one edge after any flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| lf_clk | input | 1 | Slow clock, sampled as data |
| load_we | input | 1 | Load-value write strobe |
| load_data | input | 16 | Value for load register and counter |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_slow | input | 1 | Source select: 1 slow input, 0 fast clock |
| cfg_sysdiv | input | 4 | First-stage divide value (fast source only) |
| cfg_pre | input | 8 | Prescale divide value |
| cfg_autorel | input | 1 | Auto-reload enable |
| en_req | input | 1 | Enable request pulse |
| dis_req | input | 1 | Disable request pulse |
| flag_clr | input | 3 | Flag clear: bit0 zero, bit1 enable ack, bit2 disable ack |
| enabled | output | 1 | Channel running status |
| count | output | 16 | Current counter value |
| zero_flag | output | 1 | Sticky zero-reached flag |
| en_ack | output | 1 | Sticky enable-confirmed flag |
| dis_ack | output | 1 | Sticky disable-confirmed flag |
| irq | output | 1 | Registered OR of the three flags |

## Verification
Enable and disable status are due two edges after the request edge, so the bench drives a strobe on one falling edge and checks on the second falling edge after it. Divider and counter latency only adds a fixed offset to every count step. Count timing is therefore checked as the exact distance in cycles between two successive reload events, which cancels that offset. Held and ignored behaviour is checked by reading `count` over a window of falling edges after the stimulus.

// File: rtl/dtimer_pkg.sv
package dtimer_pkg;
  localparam int DT_CNT_W = 16;
  localparam int DT_SYS_W = 4;
  localparam int DT_PRE_W = 8;

  localparam int FLG_ZERO = 0;
  localparam int FLG_ENA  = 1;
  localparam int FLG_DIS  = 2;
  localparam int FLG_N    = 3;

  typedef enum logic {SRC_FAST = 1'b0, SRC_SLOW = 1'b1} src_e;
endpackage

// File: rtl/dtimer_sync_edge.sv
module dtimer_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_pulse
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], async_in};
  end

  assign rise_pulse = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/dtimer_div_stage.sv
module dtimer_div_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         in_pulse,
  input  logic [W-1:0] div,
  output logic         out_pulse
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt       <= '0;
      out_pulse <= 1'b0;
    end else begin
      out_pulse <= 1'b0;
      if (in_pulse) begin
        if (cnt >= div) begin
          cnt       <= '0;
          out_pulse <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dtimer_counter.sv
module dtimer_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             autorel,
  input  logic             load_we,
  input  logic [CNT_W-1:0] load_data,
  output logic [CNT_W-1:0] count,
  output logic             zero_evt
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] reload_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      count      <= '0;
      reload_val <= '0;
      zero_evt   <= 1'b0;
    end else begin
      zero_evt <= 1'b0;
      if (!run && load_we) begin
        reload_val <= load_data;
        count      <= load_data;
      end else if (run && tick && count != '0) begin
        if (count == ONE) begin
          count    <= autorel ? reload_val : '0;
          zero_evt <= 1'b1;
        end else begin
          count <= count - ONE;
        end
      end
    end
  end
endmodule

// File: rtl/dtimer_chan.sv
module dtimer_chan
  import dtimer_pkg::*;
#(
  parameter int CNT_W = DT_CNT_W,
  parameter int SYS_W = DT_SYS_W,
  parameter int PRE_W = DT_PRE_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lf_clk,
  input  logic             load_we,
  input  logic [CNT_W-1:0] load_data,
  input  logic             cfg_we,
  input  logic             cfg_slow,
  input  logic [SYS_W-1:0] cfg_sysdiv,
  input  logic [PRE_W-1:0] cfg_pre,
  input  logic             cfg_autorel,
  input  logic             en_req,
  input  logic             dis_req,
  input  logic [FLG_N-1:0] flag_clr,
  output logic             enabled,
  output logic [CNT_W-1:0] count,
  output logic             zero_flag,
  output logic             en_ack,
  output logic             dis_ack,
  output logic             irq
);
  src_e             src_q;
  logic [SYS_W-1:0] sysdiv_q;
  logic [PRE_W-1:0] pre_q;
  logic             autorel_q;
  logic             en_q, dis_q, run;
  logic             lf_rise, stage1_tick, stage2_in, tick, zero_evt;
  logic [FLG_N-1:0] flags_q, flags_set, flags_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q     <= SRC_FAST;
      sysdiv_q  <= '0;
      pre_q     <= '0;
      autorel_q <= 1'b0;
    end else if (cfg_we) begin
      src_q     <= src_e'(cfg_slow);
      sysdiv_q  <= cfg_sysdiv;
      pre_q     <= cfg_pre;
      autorel_q <= cfg_autorel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      dis_q <= 1'b0;
      run   <= 1'b0;
    end else begin
      en_q  <= en_req;
      dis_q <= dis_req;
      if (dis_q)     run <= 1'b0;
      else if (en_q) run <= 1'b1;
    end
  end

  dtimer_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(lf_clk), .rise_pulse(lf_rise)
  );

  dtimer_div_stage #(.W(SYS_W)) u_sysdiv (
    .clk(clk), .rst(rst), .run(run), .in_pulse(src_q == SRC_FAST),
    .div(sysdiv_q), .out_pulse(stage1_tick)
  );

  assign stage2_in = (src_q == SRC_SLOW) ? lf_rise : stage1_tick;

  dtimer_div_stage #(.W(PRE_W)) u_prediv (
    .clk(clk), .rst(rst), .run(run), .in_pulse(stage2_in),
    .div(pre_q), .out_pulse(tick)
  );

  dtimer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run(run), .tick(tick), .autorel(autorel_q),
    .load_we(load_we), .load_data(load_data), .count(count), .zero_evt(zero_evt)
  );

  always_comb begin
    flags_set           = '0;
    flags_set[FLG_ZERO] = zero_evt;
    flags_set[FLG_ENA]  = en_q & ~dis_q;
    flags_set[FLG_DIS]  = dis_q;
    flags_nxt           = (flags_q & ~flag_clr) | flags_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      irq     <= 1'b0;
    end else begin
      flags_q <= flags_nxt;
      irq     <= |flags_nxt;
    end
  end

  assign enabled   = run;
  assign zero_flag = flags_q[FLG_ZERO];
  assign en_ack    = flags_q[FLG_ENA];
  assign dis_ack   = flags_q[FLG_DIS];
endmodule

// File: rtl/dtimer_chan_chk.sv
module dtimer_chan_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             load_we,
  input logic             en_req,
  input logic             dis_req,
  input logic             enabled,
  input logic [CNT_W-1:0] count,
  input logic             zero_flag,
  input logic             en_ack,
  input logic             dis_ack,
  input logic             irq
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (count == '0 && !enabled && !zero_flag && !irq));

  assert_enable_ack_R2: assert property (@(posedge clk) disable iff (rst)
    (en_req && !dis_req) |=> ##1 (en_ack && enabled));

  assert_disable_ack_R10: assert property (@(posedge clk) disable iff (rst)
    dis_req |=> ##1 (dis_ack && !enabled));

  assert_hold_when_off_R8: assert property (@(posedge clk) disable iff (rst)
    (!enabled && !load_we) |=> $stable(count));

  assert_rest_at_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && !load_we) |=> (count == '0));

  assert_irq_follows_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(zero_flag) |-> irq);
endmodule

bind dtimer_chan dtimer_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .load_we(load_we), .en_req(en_req), .dis_req(dis_req),
  .enabled(enabled), .count(count), .zero_flag(zero_flag), .en_ack(en_ack),
  .dis_ack(dis_ack), .irq(irq)
);

// File: tb/tb_dtimer_chan.sv
module tb_dtimer_chan;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lf_clk = 1'b0;
  logic        load_we = 1'b0;
  logic [15:0] load_data = '0;
  logic        cfg_we = 1'b0;
  logic        cfg_slow = 1'b0;
  logic [3:0]  cfg_sysdiv = '0;
  logic [7:0]  cfg_pre = '0;
  logic        cfg_autorel = 1'b0;
  logic        en_req = 1'b0;
  logic        dis_req = 1'b0;
  logic [2:0]  flag_clr = '0;
  logic        enabled, zero_flag, en_ack, dis_ack, irq;
  logic [15:0] count;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit lf_on = 1'b0;

  dtimer_chan dut (
    .clk(clk), .rst(rst), .lf_clk(lf_clk), .load_we(load_we), .load_data(load_data),
    .cfg_we(cfg_we), .cfg_slow(cfg_slow), .cfg_sysdiv(cfg_sysdiv), .cfg_pre(cfg_pre),
    .cfg_autorel(cfg_autorel), .en_req(en_req), .dis_req(dis_req), .flag_clr(flag_clr),
    .enabled(enabled), .count(count), .zero_flag(zero_flag), .en_ack(en_ack),
    .dis_ack(dis_ack), .irq(irq)
  );

  always #10 clk = ~clk;

  // slow clock: 8 main cycles per period when on
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (lf_on && (cyc % 4 == 0)) lf_clk <= ~lf_clk;
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_en();
    @(negedge clk); en_req = 1'b1; @(negedge clk); en_req = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_dis();
    @(negedge clk); dis_req = 1'b1; @(negedge clk); dis_req = 1'b0; @(negedge clk);
  endtask

  task automatic write_cfg(input bit slow, input int s, input int p, input bit ar);
    @(negedge clk);
    cfg_we = 1'b1; cfg_slow = slow; cfg_sysdiv = 4'(s); cfg_pre = 8'(p); cfg_autorel = ar;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic write_load(input int v);
    @(negedge clk); load_we = 1'b1; load_data = 16'(v);
    @(negedge clk); load_we = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk); flag_clr = 3'b111; @(negedge clk); flag_clr = 3'b000;
  endtask

  // cycles between two successive reload events (count 1 -> n)
  task automatic measure(input int n, output int period);
    int prev, t0, hits;
    prev = count; hits = 0; t0 = 0; period = -1;
    for (int i = 0; i < 20000 && hits < 2; i++) begin
      @(negedge clk);
      if (prev == 1 && count == n) begin
        if (hits == 1) period = cyc - t0;
        t0 = cyc; hits++;
      end
      prev = count;
    end
  endtask

  localparam int NV = 4;
  localparam int VS[NV] = '{0, 1, 3, 0};
  localparam int VP[NV] = '{0, 2, 0, 4};
  localparam int VN[NV] = '{5, 4, 3, 2};
  localparam int VE[NV] = '{5, 24, 12, 10};

  initial begin
    int per, held, nxt;
    idle(3);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 enabled", enabled, 0);
    chk("R1 flags", {zero_flag, en_ack, dis_ack, irq}, 0);

    // R3/R6 vector walk: auto-reload period on fast source
    for (int v = 0; v < NV; v++) begin
      pulse_dis();
      write_cfg(1'b0, VS[v], VP[v], 1'b1);
      write_load(VN[v]);
      pulse_en();
      measure(VN[v], per);
      chk($sformatf("R3 R6 vector %0d period", v), per, VE[v]);
      chk("R6 zero flag after reload", zero_flag, 1);
    end
    pulse_dis();
    clear_flags();

    // R2 enable timing
    @(negedge clk); en_req = 1'b1;
    @(negedge clk); en_req = 1'b0;
    chk("R2 not yet enabled", enabled, 0);
    @(negedge clk);
    chk("R2 enabled", enabled, 1);
    chk("R2 en_ack", en_ack, 1);
    @(negedge clk);
    chk("R11 irq from en_ack", irq, 1);

    // R10 disable timing
    @(negedge clk); dis_req = 1'b1;
    @(negedge clk); dis_req = 1'b0;
    chk("R10 still enabled", enabled, 1);
    @(negedge clk);
    chk("R10 disabled", enabled, 0);
    chk("R10 dis_ack", dis_ack, 1);

    // R10 simultaneous requests: disable wins
    @(negedge clk); en_req = 1'b1; dis_req = 1'b1;
    @(negedge clk); en_req = 1'b0; dis_req = 1'b0;
    @(negedge clk);
    chk("R10 disable wins", enabled, 0);

    // R11 individual clears
    @(negedge clk); flag_clr = 3'b010;
    @(negedge clk); flag_clr = 3'b000;
    chk("R11 en_ack cleared", en_ack, 0);
    chk("R11 dis_ack kept", dis_ack, 1);
    clear_flags();
    @(negedge clk);
    chk("R11 irq low", irq, 0);

    // R4 slow source: 8 cycles per lf period, P=1, N=3 -> 48
    lf_on = 1'b1;
    write_cfg(1'b1, 7, 1, 1'b1);
    write_load(3);
    pulse_en();
    measure(3, per);
    chk("R4 slow period", per, 48);
    pulse_dis();
    lf_on = 1'b0;
    clear_flags();

    // R5 one-shot
    write_cfg(1'b0, 0, 0, 1'b0);
    write_load(3);
    pulse_en();
    idle(12);
    chk("R5 count rests at zero", count, 0);
    chk("R5 zero flag set", zero_flag, 1);
    idle(20);
    chk("R5 flag sticky", zero_flag, 1);
    @(negedge clk); flag_clr = 3'b001;
    @(negedge clk); flag_clr = 3'b000;
    chk("R11 zero flag cleared", zero_flag, 0);
    pulse_dis();
    clear_flags();

    // R7 load zero
    write_cfg(1'b0, 0, 0, 1'b1);
    write_load(0);
    pulse_en();
    idle(30);
    chk("R7 count zero", count, 0);
    chk("R7 no zero flag", zero_flag, 0);
    pulse_dis();

    // R8 hold and resume; step every 10 cycles
    write_cfg(1'b0, 0, 9, 1'b0);
    write_load(100);
    pulse_en();
    idle(35);
    pulse_dis();
    held = count;
    chk("R8 counted some", (held < 100 && held > 90) ? 1 : 0, 1);
    idle(50);
    chk("R8 held", count, held);
    pulse_en();
    nxt = count;
    for (int i = 0; i < 40 && nxt == held; i++) begin
      @(negedge clk); nxt = count;
    end
    chk("R8 resume value", nxt, held - 1);

    // R9 write while enabled ignored
    per = count;
    @(negedge clk); load_we = 1'b1; load_data = 16'h1234;
    @(negedge clk); load_we = 1'b0;
    chk("R9 count not loaded", (count == 16'h1234) ? 1 : 0, 0);
    chk("R9 count near old", (count <= per && count + 2 >= per) ? 1 : 0, 1);
    pulse_dis();
    chk("R9 still not loaded", (count == 16'h1234) ? 1 : 0, 0);

    // R9 stored load value unchanged: auto-reload to 2 after write attempt
    write_cfg(1'b0, 0, 0, 1'b1);
    write_load(2);
    pulse_en();
    @(negedge clk); load_we = 1'b1; load_data = 16'd7;
    @(negedge clk); load_we = 1'b0;
    measure(2, per);
    chk("R9 reload value kept", per, 2);
    pulse_dis();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule